// File: doc/BRIEF.md
# Overlay Memory Address Decoder

This block sits between a DSP core and its memories. It takes one 14-bit program-space or data-space address per cycle and decides where the access goes: the on-chip RAM, a small control-register file, or the external bus. The lower 8K-word half of each space has a fixed mapping. The upper 8K-word half is bank-switched by an overlay value, with one overlay value per space. When the overlay value selects an external bank, the bank number becomes the top external address bit. A mode input can move the lower half of program space onto the external bus.

Internal accesses finish in the same cycle. An external access drives an active-low strobe and holds the core through a programmable number of wait cycles by lowering `ready`. The core must keep its request steady until `ready` returns high. While the access is stalled, the block presents the external address it latched at the start of the access, so any change on the core address does not reach the bus. An upper-half access with a reserved overlay value does nothing, apart from raising an error flag for that cycle.

Top module: `ovlyDecoder`

## Requirements
- R1: An address with bit 13 clear selects internal RAM (`ramEnable`=1, strobe high), whatever the overlay value. This holds in data space, and in program space while `progExtLow`=0.
- R2: An address in 0x2000–0x3FFF with overlay value 0 selects internal RAM.
- R3: An address in 0x2000–0x3FFF with overlay value 1 starts an external access. `extAddr[13]`=0 and `extAddr[12:0]` carries the address bits 12:0.
- R4: An address in 0x2000–0x3FFF with overlay value 2 starts an external access with `extAddr[13]`=1 and `extAddr[12:0]` equal to the address bits 12:0.
- R5: In data space (`reqSpace`=1), addresses 0x3FE0–0x3FFF assert `regSelect` and never touch RAM or the bus, whatever the overlay value. 0x3FDF is still RAM.
- R6: An upper-half address with overlay value 3 performs no access (no RAM enable, no register select, strobe high). It raises `ovlyError` and keeps `ready` high in that cycle.
- R7: With `progExtLow`=1, a program-space address with bit 13 clear is external with `extAddr[13]`=0. An upper program address is internal RAM for overlay value 0 and an error for any other overlay value. Data space is unaffected.
- R8: RAM and register-file accesses keep `ready` high in the request cycle.
- R9: An external access with wait count N holds `ready` low for exactly N cycles, starting with the request cycle. With N=0, `ready` never drops.
- R10: `extStrobeN` is low from the request cycle through the cycle in which `ready` returns high (N+1 cycles in all). `extAddr` is held at the value latched at the start of the access even if `addr` changes during the stall.
- R11: During and right after reset, with no request, `ready`=1, `extStrobeN`=1, and `ramEnable`, `regSelect` and `ovlyError` are 0, with `extAddr`=0.
- R12: Program space has no register carve-out: program address 0x3FE0 with overlay value 0 is RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Core access request |
| reqSpace | input | 1 | 0 = program space, 1 = data space |
| addr | input | 14 | Core word address |
| pmOverlay | input | 2 | Program-space overlay value |
| dmOverlay | input | 2 | Data-space overlay value |
| progExtLow | input | 1 | Moves lower program half to the external bus |
| waitCount | input | 3 | Wait cycles for an external access |
| ramEnable | output | 1 | Internal RAM access |
| regSelect | output | 1 | Control-register file access |
| ovlyError | output | 1 | Reserved overlay value used |
| extAddr | output | 14 | External address (bank bit + 13 low bits), 0 when idle |
| extStrobeN | output | 1 | Active-low external strobe |
| ready | output | 1 | Access completes this cycle |

## Verification
Each overlay value (0 through 3) is applied to the same upper-half addresses in both spaces. This separates bank-bit steering from reserved-value handling. Addresses on either side of the register carve-out (0x3FDF, 0x3FE0, 0x3FFF) are issued in both spaces, which shows whether the carve-out is confined to data space and whether it takes priority over the overlay value. External accesses are run with wait counts of 0, 1, 3, 5 and 7, and back to back. During one stall the core address is deliberately changed, which separates a latched bus address from a live one. With the mode input set, lower-half program addresses are sent out and the rule that the program overlay value must be 0 is exercised.

// File: rtl/ovly_pkg.sv
package ovly_pkg;

  // Where one core access is routed.
  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_RAM,
    TGT_REG,
    TGT_EXT,
    TGT_ERR
  } target_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic capture;   // latch the external address
    logic useHeld;   // drive the latched address on the bus
    logic strobe;    // an external access is in progress
    logic grant;     // new decodes may reach the outputs
  } ctrl_s;

endpackage

// File: rtl/ovlyDecodeDp.sv
module ovlyDecodeDp
  import ovly_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int OVLY_W    = 2,
  parameter int REG_WORDS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqSpace,
  input  logic [ADDR_W-1:0] addr,
  input  logic [OVLY_W-1:0] pmOverlay,
  input  logic [OVLY_W-1:0] dmOverlay,
  input  logic              progExtLow,
  input  ctrl_s             ctrl,
  output target_e           target,
  output logic              ramEnable,
  output logic              regSelect,
  output logic              ovlyError,
  output logic [ADDR_W-1:0] extAddr
);

  localparam int HALF_W = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] REG_BASE = ADDR_W'((1 << ADDR_W) - REG_WORDS);

  logic              upperHalf;
  logic              regHit;
  logic              extBank;
  logic [OVLY_W-1:0] ovly;
  logic [ADDR_W-1:0] liveExt;
  logic [ADDR_W-1:0] heldExt;

  assign upperHalf = addr[ADDR_W-1];
  assign ovly      = reqSpace ? dmOverlay : pmOverlay;

  // The register carve-out exists only if it has a non-zero size.
  generate
    if (REG_WORDS > 0) begin : gRegWin
      assign regHit = reqSpace && (addr >= REG_BASE);
    end else begin : gNoRegWin
      assign regHit = 1'b0;
    end
  endgenerate

  // Route decode
  always_comb begin
    target  = TGT_NONE;
    extBank = 1'b0;
    if (!reqValid) begin
      target = TGT_NONE;
    end else if (regHit) begin
      target = TGT_REG;
    end else if (!upperHalf) begin
      target = (!reqSpace && progExtLow) ? TGT_EXT : TGT_RAM;
    end else if (!reqSpace && progExtLow) begin
      target = (ovly == '0) ? TGT_RAM : TGT_ERR;
    end else begin
      if (ovly == OVLY_W'(0)) begin
        target = TGT_RAM;
      end else if (ovly == OVLY_W'(1)) begin
        target = TGT_EXT;
      end else if (ovly == OVLY_W'(2)) begin
        target  = TGT_EXT;
        extBank = 1'b1;
      end else begin
        target = TGT_ERR;
      end
    end
  end

  assign liveExt = {extBank, addr[HALF_W-1:0]};

  // Bus address held for the length of a stalled access
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldExt <= '0;
    end else if (ctrl.capture) begin
      heldExt <= liveExt;
    end
  end

  always_comb begin
    if (ctrl.useHeld) begin
      extAddr = heldExt;
    end else if (ctrl.strobe) begin
      extAddr = liveExt;
    end else begin
      extAddr = '0;
    end
  end

  assign ramEnable = ctrl.grant && (target == TGT_RAM);
  assign regSelect = ctrl.grant && (target == TGT_REG);
  assign ovlyError = ctrl.grant && (target == TGT_ERR);

endmodule

// File: rtl/ovlyDecodeCtrl.sv
module ovlyDecodeCtrl
  import ovly_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  target_e           target,
  input  logic [WAIT_W-1:0] waitCount,
  output ctrl_s             ctrl,
  output logic              ready
);

  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  state_e            state;
  state_e            stateNext;
  logic [WAIT_W-1:0] cnt;
  logic [WAIT_W-1:0] cntNext;
  logic              extReq;
  logic              needStall;

  assign extReq    = (target == TGT_EXT);
  assign needStall = extReq && (waitCount != '0);

  always_comb begin
    ctrl      = '0;
    ready     = 1'b1;
    stateNext = state;
    cntNext   = cnt;
    unique case (state)
      ST_IDLE: begin
        ctrl.grant   = 1'b1;
        ctrl.strobe  = extReq;
        ctrl.capture = needStall;
        ready        = !needStall;
        if (needStall) begin
          stateNext = ST_WAIT;
          cntNext   = WAIT_W'(waitCount - 1'b1);
        end
      end
      ST_WAIT: begin
        ctrl.strobe  = 1'b1;
        ctrl.useHeld = 1'b1;
        ready        = (cnt == '0);
        if (cnt == '0) begin
          stateNext = ST_IDLE;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      default: begin
        stateNext = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

endmodule

// File: rtl/ovlyDecoder.sv
module ovlyDecoder
  import ovly_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int OVLY_W    = 2,
  parameter int WAIT_W    = 3,
  parameter int REG_WORDS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqSpace,
  input  logic [ADDR_W-1:0] addr,
  input  logic [OVLY_W-1:0] pmOverlay,
  input  logic [OVLY_W-1:0] dmOverlay,
  input  logic              progExtLow,
  input  logic [WAIT_W-1:0] waitCount,
  output logic              ramEnable,
  output logic              regSelect,
  output logic              ovlyError,
  output logic [ADDR_W-1:0] extAddr,
  output logic              extStrobeN,
  output logic              ready
);

  target_e target;
  ctrl_s   ctrl;

  ovlyDecodeDp #(
    .ADDR_W   (ADDR_W),
    .OVLY_W   (OVLY_W),
    .REG_WORDS(REG_WORDS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqSpace  (reqSpace),
    .addr      (addr),
    .pmOverlay (pmOverlay),
    .dmOverlay (dmOverlay),
    .progExtLow(progExtLow),
    .ctrl      (ctrl),
    .target    (target),
    .ramEnable (ramEnable),
    .regSelect (regSelect),
    .ovlyError (ovlyError),
    .extAddr   (extAddr)
  );

  ovlyDecodeCtrl #(
    .WAIT_W(WAIT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .target   (target),
    .waitCount(waitCount),
    .ctrl     (ctrl),
    .ready    (ready)
  );

  assign extStrobeN = !ctrl.strobe;

endmodule

// File: rtl/ovlyDecoderChecker.sv
module ovlyDecoderChecker #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqSpace,
  input logic [ADDR_W-1:0] addr,
  input logic              progExtLow,
  input logic              ramEnable,
  input logic              regSelect,
  input logic              ovlyError,
  input logic [ADDR_W-1:0] extAddr,
  input logic              extStrobeN,
  input logic              ready
);

  // R1: lower half of a fresh access lands in RAM
  assert_lower_ram_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !addr[ADDR_W-1] && (reqSpace || !progExtLow) && $past(ready))
      |-> (ramEnable && extStrobeN));

  // R6: an error cycle does nothing else
  assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    ovlyError |-> (extStrobeN && !ramEnable && !regSelect && ready));

  // R8: internal targets never stall
  assert_internal_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ramEnable || regSelect) |-> ready);

  // R9: ready only returns high at the end of an external access
  assert_ready_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> !extStrobeN);

  // R10: a stalled access keeps strobe and address
  assert_hold_addr_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!extStrobeN && !ready) |=> (!extStrobeN && $stable(extAddr)));

  // R10: bus and internal targets are exclusive
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !extStrobeN |-> (!ramEnable && !regSelect));

endmodule

bind ovlyDecoder ovlyDecoderChecker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqSpace  (reqSpace),
  .addr      (addr),
  .progExtLow(progExtLow),
  .ramEnable (ramEnable),
  .regSelect (regSelect),
  .ovlyError (ovlyError),
  .extAddr   (extAddr),
  .extStrobeN(extStrobeN),
  .ready     (ready)
);

// File: tb/ovlyDecoder_bench.sv
module ovlyDecoder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqSpace = 1'b0;
  logic [13:0] addr = '0;
  logic [1:0]  pmOverlay = '0;
  logic [1:0]  dmOverlay = '0;
  logic        progExtLow = 1'b0;
  logic [2:0]  waitCount = '0;
  logic        ramEnable, regSelect, ovlyError, extStrobeN, ready;
  logic [13:0] extAddr;

  int checks = 0;
  int fails  = 0;

  // reference model state
  bit mInWait = 0;
  int mCnt    = 0;
  int mHeld   = 0;
  bit mExt    = 0;

  always #2 clk = ~clk;

  ovlyDecoder u_ovlyDecoder (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSpace(reqSpace),
    .addr(addr), .pmOverlay(pmOverlay), .dmOverlay(dmOverlay),
    .progExtLow(progExtLow), .waitCount(waitCount),
    .ramEnable(ramEnable), .regSelect(regSelect), .ovlyError(ovlyError),
    .extAddr(extAddr), .extStrobeN(extStrobeN), .ready(ready)
  );

  // Expected outputs packed as {ram, reg, err, strobeN, ready, extAddr}
  function automatic logic [18:0] expected();
    int a, ov, bank;
    bit eRam, eReg, eErr, eExt;
    a = int'(addr);
    ov = reqSpace ? int'(dmOverlay) : int'(pmOverlay);
    eRam = 0; eReg = 0; eErr = 0; eExt = 0; bank = 0;
    if (mInWait) begin
      mExt = 0;
      return {1'b0, 1'b0, 1'b0, 1'b0, (mCnt == 0), 14'(mHeld)};
    end
    if (reqValid) begin
      if (reqSpace && a >= 16352) eReg = 1;
      else if (a < 8192) begin
        if (!reqSpace && progExtLow) eExt = 1; else eRam = 1;
      end else if (!reqSpace && progExtLow) begin
        if (ov == 0) eRam = 1; else eErr = 1;
      end else if (ov == 0) eRam = 1;
      else if (ov == 1) eExt = 1;
      else if (ov == 2) begin eExt = 1; bank = 1; end
      else eErr = 1;
    end
    mExt = eExt;
    return {eRam, eReg, eErr, !eExt, !(eExt && waitCount != 0),
            eExt ? 14'(bank * 8192 + (a % 8192)) : 14'd0};
  endfunction

  task automatic step(input string tag);
    logic [18:0] exp, act;
    #1;
    exp = expected();
    act = {ramEnable, regSelect, ovlyError, extStrobeN, ready, extAddr};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {ram,reg,err,strbN,rdy,addr} actual=%b_%h expected=%b_%h",
               tag, act[18:14], act[13:0], exp[18:14], exp[13:0]);
    end
    @(posedge clk);
    if (mInWait) begin
      if (mCnt == 0) mInWait = 0; else mCnt--;
    end else if (mExt && waitCount != 0) begin
      mInWait = 1;
      mCnt    = int'(waitCount) - 1;
      mHeld   = int'(exp[13:0]);
    end
    @(negedge clk);
  endtask

  task automatic access(input bit sp, input int a, input int ov, input int n,
                        input string tag);
    reqValid  = 1;
    reqSpace  = sp;
    addr      = 14'(a);
    if (sp) dmOverlay = 2'(ov); else pmOverlay = 2'(ov);
    waitCount = 3'(n);
    step(tag);
    while (mInWait) step(tag);
    reqValid = 0;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    step("R11 in reset");
    @(negedge clk);
    rstN = 1;
    step("R11 after reset");

    // R1 lower half with any overlay value
    access(1, 'h0005, 1, 2, "R1 data lower ovl1");
    access(0, 'h1FFF, 2, 2, "R1 prog lower ovl2");
    access(1, 'h0ABC, 3, 0, "R1 data lower ovl3");
    // R2 upper half overlay 0
    access(0, 'h2000, 0, 4, "R2 prog upper ovl0");
    access(1, 'h3FDF, 0, 4, "R2 R5 data 0x3FDF ovl0");
    // R3 / R4 overlay banks, R9 / R10 wait lengths
    access(1, 'h2ABC, 1, 0, "R3 R9 ovl1 no wait");
    access(0, 'h3FFF, 1, 3, "R3 R10 ovl1 wait3");
    access(1, 'h2001, 2, 5, "R4 R9 ovl2 wait5");
    access(0, 'h3456, 2, 1, "R4 R9 ovl2 wait1");
    // R5 register carve-out over all overlay values
    access(1, 'h3FE0, 0, 3, "R5 reg low ovl0");
    access(1, 'h3FFF, 1, 3, "R5 reg top ovl1");
    access(1, 'h3FF0, 3, 3, "R5 reg ovl3");
    // R12 no carve-out in program space
    access(0, 'h3FE0, 0, 3, "R12 prog 0x3FE0");
    access(0, 'h3FE0, 2, 0, "R12 prog 0x3FE0 ovl2");
    // R6 reserved overlay
    access(1, 'h2100, 3, 6, "R6 data ovl3");
    access(0, 'h3000, 3, 6, "R6 prog ovl3");
    // R8 internal back to back
    reqValid = 1; reqSpace = 1; dmOverlay = 0; waitCount = 7;
    for (int i = 0; i < 4; i++) begin
      addr = 14'(16'h3FDE + i);
      step("R8 internal burst");
    end
    reqValid = 0;
    // R9 maximum wait, back to back externals
    access(1, 'h2222, 1, 7, "R9 wait7 first");
    access(1, 'h2223, 2, 7, "R9 wait7 second");
    // R10 address changes during stall
    reqValid = 1; reqSpace = 0; pmOverlay = 2; addr = 14'h2A5A; waitCount = 4;
    step("R10 stall start");
    addr = 14'h0111;
    while (mInWait) step("R10 held address");
    reqValid = 0;
    // R7 program mode pin
    progExtLow = 1;
    access(0, 'h0123, 0, 2, "R7 prog lower ext");
    access(0, 'h1FFF, 1, 0, "R7 prog lower ext nowait");
    access(0, 'h2222, 0, 2, "R7 prog upper ovl0 ram");
    access(0, 'h2222, 1, 2, "R7 prog upper ovl1 err");
    access(0, 'h3333, 2, 2, "R7 prog upper ovl2 err");
    access(1, 'h0444, 1, 2, "R7 data lower ram");
    access(1, 'h2444, 2, 1, "R7 data upper ext");
    progExtLow = 0;
    step("R11 idle");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule